// File: doc/BRIEF.md
# Nested Suspend/Resume Controller for Flash Operations

This block tracks long flash operations on behalf of a command interface. A block erase or a program operation is modelled by a work counter. A suspend command pauses that counter after a fixed latency and reports the paused state in a status byte. The status byte also shows the ready level, the erase-paused and program-paused flags and a sticky command-sequence error. A level ready/busy output follows the ready bit. A 2-bit read-select output tells the read path whether to return array data, status data or query data.

A program may be started while an erase is paused, and that program may itself be paused, giving two levels of nesting. The first resume continues the program. Once that program completes, the erase stays paused until a second resume. While anything is paused, only a short list of commands is legal. Any other command raises the error bits and leaves the pause state alone.

Top module: `nest_susp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80 (bit 7 ready, all other bits 0), the ready/busy output is 1 and the read select is 0 (array).
- R2: When nothing runs and nothing is paused, command code 5 starts a program of PROG_CYCLES work cycles and code 6 starts an erase of ERASE_CYCLES work cycles. Status bit 7 and the ready/busy output go to 0 on the cycle after the command is captured, and the read select becomes 1 (status).
- R3: Code 7 (suspend), captured while an operation is running and not in its final work cycle, makes status bit 7 and the ready/busy output rise exactly SUSP_LAT clocks after the capture edge. At the same time bit 2 (program paused) or bit 6 (erase paused) rises for the operation that was paused, and the read select shows 1 (status).
- R4: Work done before a suspend is kept. An operation paused once and resumed once is busy for exactly its work cycles plus SUSP_LAT cycles in total, whatever cycle the suspend arrived on and however long the pause lasted.
- R5: Code 8 (resume), captured while paused, clears bit 7 and the matching pause bit on the next cycle, sets the read select to 1 (status) and continues the counted work.
- R6: While an erase is paused, code 5 starts a nested program and bit 6 stays 1. That program can be paused in turn (status 0xC4). The first resume continues the program, and when the program completes the status reads 0xC0. A second resume continues the erase, which then runs to completion and returns status to 0x80.
- R7: While paused, the legal codes are 0, 1, 2, 3, 4 and 8, plus 5 when only an erase is paused. Any other code sets status bits 5 and 4 and leaves bits 7, 6 and 2 unchanged.
- R8: When not busy, codes 0, 1 and 2 set the read select to 0 (array), 1 (status) and 2 (query) respectively. Code 3 clears bits 5 and 4, and code 4 (configure) changes neither status nor read select.
- R9: When nothing runs and nothing is paused, codes 7, 8, 4 and 9 to 15 leave the status byte at 0x80 and never set the error bits.
- R10: While busy (bit 7 at 0), every code except 7 is ignored: the read select stays 1 and no error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_i | input | 4 | Decoded command code |
| sts_o | output | 8 | Status byte: 7 ready, 6 erase paused, 5 and 4 sequence error, 2 program paused |
| ry_by_o | output | 1 | Level ready/busy, 1 = ready |
| rd_sel_o | output | 2 | Read source: 0 array, 1 status, 2 query |

## Verification
The bench builds the block with PROG_CYCLES=12, ERASE_CYCLES=20 and SUSP_LAT=3. With these values it can sweep the suspend point over every legal work cycle of both operation kinds. For each suspend point it checks the latency, the pause flags and the conserved busy total of work plus latency. The short counts also keep the full two-level nesting walk short enough to try every illegal code at both pause depths, and to check the clear and read-select paths between them.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  localparam logic [3:0] CMD_RD_ARRAY   = 4'd0;
  localparam logic [3:0] CMD_RD_STATUS  = 4'd1;
  localparam logic [3:0] CMD_RD_QUERY   = 4'd2;
  localparam logic [3:0] CMD_CLR_STATUS = 4'd3;
  localparam logic [3:0] CMD_CONFIG     = 4'd4;
  localparam logic [3:0] CMD_PROGRAM    = 4'd5;
  localparam logic [3:0] CMD_ERASE      = 4'd6;
  localparam logic [3:0] CMD_SUSPEND    = 4'd7;
  localparam logic [3:0] CMD_RESUME     = 4'd8;

  localparam logic [1:0] RD_ARRAY  = 2'd0;
  localparam logic [1:0] RD_STATUS = 2'd1;
  localparam logic [1:0] RD_QUERY  = 2'd2;

  typedef enum logic [1:0] {CTX_IDLE, CTX_RUN, CTX_PEND, CTX_SUSP} ctx_e;

  typedef struct packed {
    logic is_read;
    logic is_clear;
    logic is_prog;
    logic is_erase;
    logic is_susp;
    logic is_resume;
    logic is_other;
  } cmd_dec_t;
endpackage

// File: rtl/nsc_cmd_decode.sv
module nsc_cmd_decode
  import nsc_pkg::*;
(
  input  logic       valid_i,
  input  logic [3:0] cmd_i,
  output cmd_dec_t   dec_o
);
  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      dec_o.is_read   = (cmd_i == CMD_RD_ARRAY) || (cmd_i == CMD_RD_STATUS) ||
                        (cmd_i == CMD_RD_QUERY);
      dec_o.is_clear  = (cmd_i == CMD_CLR_STATUS);
      dec_o.is_prog   = (cmd_i == CMD_PROGRAM);
      dec_o.is_erase  = (cmd_i == CMD_ERASE);
      dec_o.is_susp   = (cmd_i == CMD_SUSPEND);
      dec_o.is_resume = (cmd_i == CMD_RESUME);
      dec_o.is_other  = (cmd_i > CMD_RESUME);
    end
  end
endmodule

// File: rtl/nsc_down_cnt.sv
module nsc_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (dec_i && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/nsc_cmd_gate.sv
module nsc_cmd_gate
  import nsc_pkg::*;
(
  input  cmd_dec_t dec_i,
  input  ctx_e     e_st_i,
  input  ctx_e     p_st_i,
  input  logic     e_last_i,
  input  logic     p_last_i,
  output logic     busy_o,
  output logic     start_erase_o,
  output logic     start_prog_o,
  output logic     susp_erase_o,
  output logic     susp_prog_o,
  output logic     res_erase_o,
  output logic     res_prog_o,
  output logic     acc_read_o,
  output logic     acc_clear_o,
  output logic     seq_err_o
);
  logic any_susp, quiet, held;

  always_comb begin
    busy_o   = (e_st_i == CTX_RUN) || (e_st_i == CTX_PEND) ||
               (p_st_i == CTX_RUN) || (p_st_i == CTX_PEND);
    any_susp = (e_st_i == CTX_SUSP) || (p_st_i == CTX_SUSP);
    quiet    = !busy_o && !any_susp;
    held     = !busy_o && any_susp;

    start_erase_o = dec_i.is_erase && quiet;
    start_prog_o  = dec_i.is_prog && (quiet || (held && p_st_i == CTX_IDLE));
    // a suspend on the final work cycle loses to completion
    susp_prog_o   = dec_i.is_susp && (p_st_i == CTX_RUN) && !p_last_i;
    susp_erase_o  = dec_i.is_susp && (e_st_i == CTX_RUN) && !e_last_i;
    res_prog_o    = dec_i.is_resume && held && (p_st_i == CTX_SUSP);
    res_erase_o   = dec_i.is_resume && held && (p_st_i == CTX_IDLE);
    acc_read_o    = dec_i.is_read && !busy_o;
    acc_clear_o   = dec_i.is_clear && !busy_o;
    seq_err_o     = held && (dec_i.is_erase || dec_i.is_susp || dec_i.is_other ||
                             (dec_i.is_prog && p_st_i != CTX_IDLE));
  end
endmodule

// File: rtl/nest_susp_ctrl.sv
module nest_susp_ctrl
  import nsc_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 64,
  parameter int unsigned PROG_CYCLES  = 24,
  parameter int unsigned SUSP_LAT     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_i,
  output logic [7:0] sts_o,
  output logic       ry_by_o,
  output logic [1:0] rd_sel_o
);
  localparam int unsigned MAX_AB = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int unsigned MAX_V  = (MAX_AB > SUSP_LAT) ? MAX_AB : SUSP_LAT;
  localparam int unsigned CW     = $clog2(MAX_V + 1);
  localparam int unsigned N_CNT  = 3;
  localparam int unsigned I_ERS  = 0;
  localparam int unsigned I_PRG  = 1;
  localparam int unsigned I_LAT  = 2;

  cmd_dec_t dec;
  ctx_e     e_st_q, e_st_d, p_st_q, p_st_d;
  logic     busy, start_erase, start_prog, susp_erase, susp_prog;
  logic     res_erase, res_prog, acc_read, acc_clear, seq_err;
  logic     err_q;
  logic [1:0] rd_sel_q;

  logic [N_CNT-1:0] cnt_load, cnt_dec, cnt_last;
  logic [CW-1:0]    cnt_val [N_CNT];

  nsc_cmd_decode u_dec (
    .valid_i (cmd_valid_i),
    .cmd_i   (cmd_i),
    .dec_o   (dec)
  );

  nsc_cmd_gate u_gate (
    .dec_i         (dec),
    .e_st_i        (e_st_q),
    .p_st_i        (p_st_q),
    .e_last_i      (cnt_last[I_ERS]),
    .p_last_i      (cnt_last[I_PRG]),
    .busy_o        (busy),
    .start_erase_o (start_erase),
    .start_prog_o  (start_prog),
    .susp_erase_o  (susp_erase),
    .susp_prog_o   (susp_prog),
    .res_erase_o   (res_erase),
    .res_prog_o    (res_prog),
    .acc_read_o    (acc_read),
    .acc_clear_o   (acc_clear),
    .seq_err_o     (seq_err)
  );

  always_comb begin
    cnt_load[I_ERS] = start_erase;
    cnt_val[I_ERS]  = CW'(ERASE_CYCLES);
    cnt_dec[I_ERS]  = (e_st_q == CTX_RUN);
    cnt_load[I_PRG] = start_prog;
    cnt_val[I_PRG]  = CW'(PROG_CYCLES);
    cnt_dec[I_PRG]  = (p_st_q == CTX_RUN);
    cnt_load[I_LAT] = susp_erase || susp_prog;
    cnt_val[I_LAT]  = CW'(SUSP_LAT);
    cnt_dec[I_LAT]  = (e_st_q == CTX_PEND) || (p_st_q == CTX_PEND);
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    nsc_down_cnt #(.W(CW)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (cnt_load[g]),
      .load_val_i (cnt_val[g]),
      .dec_i      (cnt_dec[g]),
      .last_o     (cnt_last[g])
    );
  end

  function automatic ctx_e ctx_next(ctx_e cur, logic start, logic last,
                                    logic susp, logic lat_last, logic resume);
    ctx_e nxt = cur;
    case (cur)
      CTX_IDLE: if (start) nxt = CTX_RUN;
      CTX_RUN:  if (last) nxt = CTX_IDLE; else if (susp) nxt = CTX_PEND;
      CTX_PEND: if (lat_last) nxt = CTX_SUSP;
      CTX_SUSP: if (resume) nxt = CTX_RUN;
      default:  nxt = CTX_IDLE;
    endcase
    return nxt;
  endfunction

  always_comb begin
    e_st_d = ctx_next(e_st_q, start_erase, cnt_last[I_ERS], susp_erase,
                      cnt_last[I_LAT], res_erase);
    p_st_d = ctx_next(p_st_q, start_prog, cnt_last[I_PRG], susp_prog,
                      cnt_last[I_LAT], res_prog);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_st_q   <= CTX_IDLE;
      p_st_q   <= CTX_IDLE;
      err_q    <= 1'b0;
      rd_sel_q <= RD_ARRAY;
    end else begin
      e_st_q <= e_st_d;
      p_st_q <= p_st_d;
      if (seq_err)        err_q <= 1'b1;
      else if (acc_clear) err_q <= 1'b0;
      if (start_erase || start_prog || susp_erase || susp_prog || res_erase || res_prog)
        rd_sel_q <= RD_STATUS;
      else if (acc_read)
        rd_sel_q <= cmd_i[1:0];
    end
  end

  assign sts_o    = {!busy, (e_st_q == CTX_SUSP), err_q, err_q, 1'b0,
                     (p_st_q == CTX_SUSP), 2'b00};
  assign ry_by_o  = !busy;
  assign rd_sel_o = rd_sel_q;
endmodule

// File: rtl/nsc_checker.sv
module nsc_checker
  import nsc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [3:0] cmd_i,
  input logic [7:0] sts_o,
  input logic       ry_by_o,
  input logic [1:0] rd_sel_o
);
  AST_PROG_SUSP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[2] |-> (sts_o[7] && ry_by_o)); // R3

  AST_RESUME_GOES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_RESUME && sts_o[7] && (sts_o[2] || sts_o[6]))
      |=> !sts_o[7]); // R5

  AST_ERASE_UNPAUSE_BY_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_o[6]) |-> $past(cmd_valid_i && cmd_i == CMD_RESUME)); // R6

  AST_ERR_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[5]) |-> $past(cmd_valid_i)); // R7

  AST_IDLE_SUSPEND_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_SUSPEND && sts_o[7] && !sts_o[2] && !sts_o[6])
      |=> $stable(sts_o)); // R9

  AST_BUSY_READS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_o[7] |-> (rd_sel_o == RD_STATUS)); // R10
endmodule

bind nest_susp_ctrl nsc_checker u_chk (.*);

// File: tb/tb_nest_susp_ctrl.sv
`timescale 1ns/1ps
module tb_nest_susp_ctrl;
  import nsc_pkg::*;

  localparam int P = 12;
  localparam int E = 20;
  localparam int L = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd = '0;
  logic [7:0] sts;
  logic       ry;
  logic [1:0] rd_sel;

  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  bit meas_en = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  nest_susp_ctrl #(.ERASE_CYCLES(E), .PROG_CYCLES(P), .SUSP_LAT(L)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .sts_o(sts), .ry_by_o(ry), .rd_sel_o(rd_sel));

  always @(posedge clk) if (meas_en && !sts[7]) busy_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c);
    cmd_valid = 1'b1; cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (sts[7]) break;
      @(negedge clk);
    end
  endtask

  task automatic sweep_one(input logic [3:0] opc, input int n, input int s, input int w);
    int bi;
    bi = (opc == CMD_ERASE) ? 6 : 2;
    busy_cnt = 0; meas_en = 1'b1;
    send(opc);
    chk(!sts[7] && rd_sel == RD_STATUS, "R2 start busy", sts, 8'h00);
    repeat (s - 1) @(negedge clk);
    send(CMD_SUSPEND);
    repeat (L - 1) @(negedge clk);
    chk(!sts[7], "R3 ready before latency", sts, 8'h00);
    @(negedge clk);
    chk(sts[7] && sts[bi] && ry && rd_sel == RD_STATUS, "R3 paused after latency",
        sts, 8'h80 | (1 << bi));
    repeat (w) @(negedge clk);
    send(CMD_RESUME);
    chk(!sts[7] && !sts[bi], "R5 resume clears", sts, 8'h00);
    wait_ready(n + 8);
    meas_en = 1'b0;
    chk(busy_cnt == n + L, "R4 busy total", busy_cnt, n + L);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sts == 8'h80 && ry && rd_sel == RD_ARRAY, "R1 reset", sts, 8'h80);

    // R9: no-ops when quiet
    send(CMD_SUSPEND); chk(sts == 8'h80, "R9 idle suspend", sts, 8'h80);
    send(CMD_RESUME);  chk(sts == 8'h80, "R9 idle resume", sts, 8'h80);
    for (int c = 9; c < 16; c++) begin
      send(4'(c)); chk(sts == 8'h80, "R9 idle other code", sts, 8'h80);
    end
    // R8: read select when quiet
    send(CMD_RD_QUERY);  chk(rd_sel == RD_QUERY, "R8 query", rd_sel, 2);
    send(CMD_RD_STATUS); chk(rd_sel == RD_STATUS, "R8 status", rd_sel, 1);
    send(CMD_RD_ARRAY);  chk(rd_sel == RD_ARRAY, "R8 array", rd_sel, 0);
    send(CMD_CONFIG);
    chk(sts == 8'h80 && rd_sel == RD_ARRAY, "R8 configure no effect", sts, 8'h80);

    // R3 R4 R5 sweeps over every suspend point
    for (int s = 1; s < P; s++) sweep_one(CMD_PROGRAM, P, s, s % 3);
    for (int s = 1; s < E; s++) sweep_one(CMD_ERASE, E, s, (s % 2) * 2);

    // R10: ignore while busy
    send(CMD_PROGRAM);
    send(CMD_RD_ARRAY); chk(rd_sel == RD_STATUS && !sts[7], "R10 read ignored", rd_sel, 1);
    send(CMD_ERASE);    chk(sts == 8'h00, "R10 erase ignored", sts, 8'h00);
    send(4'd13);        chk(sts == 8'h00, "R10 other ignored", sts, 8'h00);
    wait_ready(P + 4);
    chk(sts == 8'h80, "R10 back to idle", sts, 8'h80);

    // R6 R7 nested walk
    send(CMD_ERASE);
    repeat (4) @(negedge clk);
    send(CMD_SUSPEND);
    repeat (L) @(negedge clk);
    chk(sts == 8'hC0, "R6 erase paused", sts, 8'hC0);
    send(CMD_SUSPEND); chk(sts == 8'hF0, "R7 suspend illegal", sts, 8'hF0);
    send(CMD_CLR_STATUS); chk(sts == 8'hC0, "R8 clear", sts, 8'hC0);
    send(CMD_ERASE); chk(sts == 8'hF0, "R7 erase illegal", sts, 8'hF0);
    send(CMD_CLR_STATUS);
    send(CMD_RD_ARRAY); chk(rd_sel == RD_ARRAY, "R8 array while paused", rd_sel, 0);
    send(CMD_PROGRAM);
    chk(sts == 8'h40 && rd_sel == RD_STATUS, "R6 nested program runs", sts, 8'h40);
    repeat (2) @(negedge clk);
    send(CMD_SUSPEND);
    repeat (L) @(negedge clk);
    chk(sts == 8'hC4, "R6 two levels paused", sts, 8'hC4);
    send(CMD_ERASE);   chk(sts == 8'hF4, "R7 erase at depth two", sts, 8'hF4);
    send(CMD_PROGRAM); chk(sts == 8'hF4, "R7 program at depth two", sts, 8'hF4);
    send(CMD_SUSPEND); chk(sts == 8'hF4, "R7 suspend at depth two", sts, 8'hF4);
    send(4'd15);       chk(sts == 8'hF4, "R7 other at depth two", sts, 8'hF4);
    send(CMD_CLR_STATUS); chk(sts == 8'hC4, "R8 clear at depth two", sts, 8'hC4);
    send(CMD_CONFIG);  chk(sts == 8'hC4, "R7 configure legal", sts, 8'hC4);
    send(CMD_RD_QUERY); chk(rd_sel == RD_QUERY, "R8 query while paused", rd_sel, 2);
    send(CMD_RESUME);
    chk(sts == 8'h40 && rd_sel == RD_STATUS, "R5 first resume", sts, 8'h40);
    wait_ready(P + 4);
    chk(sts == 8'hC0, "R6 erase still paused", sts, 8'hC0);
    send(CMD_RESUME); chk(sts == 8'h00, "R6 second resume", sts, 8'h00);
    wait_ready(E + 4);
    chk(sts == 8'h80 && ry, "R6 erase completes", sts, 8'h80);

    finish_run();
  end
endmodule